// File: doc/BRIEF.md
# Serial Fixed-Point Slope Calculator

This block takes two points, given as four signed integer coordinates, and returns the slope between them as a signed fraction in two's-complement Q format. It forms the rise and the run internally, takes their magnitudes, and divides them with a restoring shift-subtract divider. The divider produces one quotient bit per clock, so the logic stays small at the cost of latency. The sign is applied at the end as the exclusive-or of the two difference signs. Results are truncated toward zero.

A caller pulses `start` with the four coordinates valid. The block captures them, raises `busy`, and later pulses `done` for one cycle with the result on `slope`. A vertical line (equal x coordinates) does not enter the divider. It sets `inf` and gives a full-scale code. A slope whose magnitude is one or more sets `ovf` and gives a full-scale code as well.

The controller walks through the states S_IDLE, S_DIFF, S_CLASS, S_DIV, S_PACK and S_DONE:
- S_IDLE→S_DIFF on `start` (the operands are latched).
- S_DIFF→S_CLASS always (the differences and magnitudes are registered).
- S_CLASS→S_PACK on a zero run or an oversized rise.
- S_CLASS→S_DIV otherwise (the divider is loaded).
- S_DIV→S_PACK after QW-1 quotient steps.
- S_PACK→S_DONE always (the result and flags are registered).
- S_DONE→S_IDLE always.

Top module: `slope_calc`

## Requirements
- R1: For a nonzero run with |rise| < |run|, `slope` equals sign × floor(|rise| × 2^(QW-1) / |run|). Here rise = y2-y1 and run = x2-x1. The sign is negative when exactly one of rise and run is negative. A zero rise gives code 0.
- R2: `slope` is two's complement with QW bits. The top bit weighs -1 and bit k weighs 2^-(QW-1-k), so codes span -1 to 1-2^-(QW-1). QW and the coordinate width CW are parameters.
- R3: For a nonzero run with |rise| >= |run|, `ovf`=1 and `inf`=0. `slope` is 0x7FFF (most positive) when rise and run have equal signs and 0x8000 (most negative) otherwise, shown for QW=16.
- R4: For a zero run, `inf`=1 and `ovf`=0, and no quotient steps are run. `slope` is most positive when rise >= 0 and most negative when rise < 0.
- R5: `done` is high for exactly one cycle per accepted `start`. It rises QW+2 rising edges after the edge that accepts `start` for a divided result, and 3 edges after it for the `inf` or `ovf` cases.
- R6: `busy` is high from the edge after `start` is accepted until the edge after `done`. A `start` while `busy` is high is ignored: it changes neither the result nor the operands in use, and it produces no further `done`.
- R7: A synchronous reset `rst` clears `busy`, `done`, `inf`, `ovf` and `slope` to 0.
- R8: `slope`, `inf` and `ovf` hold their values from one `done` until the next operation reaches S_PACK.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Request a computation; sampled only while idle |
| x1 | input | CW | First point abscissa, signed |
| y1 | input | CW | First point ordinate, signed |
| x2 | input | CW | Second point abscissa, signed |
| y2 | input | CW | Second point ordinate, signed |
| busy | output | 1 | Computation in progress |
| done | output | 1 | One-cycle pulse marking a valid result |
| slope | output | QW | Signed fractional slope, Q(QW-1) |
| inf | output | 1 | Run was zero; result saturated |
| ovf | output | 1 | Slope magnitude at least one; result saturated |

## Verification
The bound checker watches the handshake on every cycle. It checks that `done` lasts one cycle, that `busy` falls only right after `done`, and that the two flags never rise together. It also checks that a flagged result is always a full-scale code and that the outputs stay stable while the block is idle. The bench's scenarios are what show the numerical quotient, the truncation direction, the choice of saturation sign, the exact latency, and that a second `start` during a computation has no effect. These are checked against a reference function, both on directed corners and on seeded random coordinates.

// File: rtl/slope_pkg.sv
package slope_pkg;

    typedef enum logic [2:0] {
        S_IDLE  = 3'd0,
        S_DIFF  = 3'd1,
        S_CLASS = 3'd2,
        S_DIV   = 3'd3,
        S_PACK  = 3'd4,
        S_DONE  = 3'd5
    } slope_state_e;

endpackage

// File: rtl/slope_diff.sv
// Forms rise and run from latched coordinates and splits each into sign and magnitude.
module slope_diff #(
    parameter int CW = 16,
    localparam int DW = CW + 1
) (
    input  logic signed [CW-1:0] px1,
    input  logic signed [CW-1:0] py1,
    input  logic signed [CW-1:0] px2,
    input  logic signed [CW-1:0] py2,
    output logic [DW-1:0]        run_mag,
    output logic                 run_neg,
    output logic [DW-1:0]        rise_mag,
    output logic                 rise_neg
);
    logic signed [DW-1:0] run_s;
    logic signed [DW-1:0] rise_s;

    always_comb begin
        run_s    = DW'(px2) - DW'(px1);
        rise_s   = DW'(py2) - DW'(py1);
        run_neg  = run_s[DW-1];
        rise_neg = rise_s[DW-1];
        run_mag  = run_neg  ? DW'(-run_s)  : DW'(run_s);
        rise_mag = rise_neg ? DW'(-rise_s) : DW'(rise_s);
    end
endmodule

// File: rtl/slope_serdiv.sv
// Restoring shift-subtract divider on magnitudes; one quotient bit per step.
// Requires num < den at load, so the quotient is a pure fraction.
module slope_serdiv #(
    parameter int DW = 17,
    parameter int FW = 15
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic          step,
    input  logic [DW-1:0] num,
    input  logic [DW-1:0] den,
    output logic [FW-1:0] quo
);
    logic [DW-1:0] rem_q;
    logic [DW:0]   shifted;
    logic [DW:0]   trial;
    logic          fits;

    always_comb begin
        shifted = {rem_q, 1'b0};
        trial   = shifted - {1'b0, den};
        fits    = (shifted >= {1'b0, den});
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rem_q <= '0;
            quo   <= '0;
        end else if (load) begin
            rem_q <= num;
            quo   <= '0;
        end else if (step) begin
            if (fits) begin
                rem_q <= trial[DW-1:0];
                quo   <= {quo[FW-2:0], 1'b1};
            end else begin
                rem_q <= shifted[DW-1:0];
                quo   <= {quo[FW-2:0], 1'b0};
            end
        end
    end
endmodule

// File: rtl/slope_fmt.sv
// Applies sign and saturation to the magnitude quotient.
module slope_fmt #(
    parameter int QW = 16,
    localparam int FW = QW - 1
) (
    input  logic [FW-1:0] quo,
    input  logic          rise_neg,
    input  logic          run_neg,
    input  logic          is_inf,
    input  logic          is_ovf,
    output logic [QW-1:0] code
);
    localparam logic [QW-1:0] POS_FULL = {1'b0, {FW{1'b1}}};
    localparam logic [QW-1:0] NEG_FULL = {1'b1, {FW{1'b0}}};

    logic          neg;
    logic [QW-1:0] mag;

    always_comb begin
        neg = rise_neg ^ run_neg;
        mag = {1'b0, quo};
        if (is_inf) begin
            code = rise_neg ? NEG_FULL : POS_FULL;
        end else if (is_ovf) begin
            code = neg ? NEG_FULL : POS_FULL;
        end else begin
            code = neg ? QW'(-mag) : mag;
        end
    end
endmodule

// File: rtl/slope_calc.sv
module slope_calc
    import slope_pkg::*;
#(
    parameter int CW = 16,
    parameter int QW = 16
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 start,
    input  logic signed [CW-1:0] x1,
    input  logic signed [CW-1:0] y1,
    input  logic signed [CW-1:0] x2,
    input  logic signed [CW-1:0] y2,
    output logic                 busy,
    output logic                 done,
    output logic [QW-1:0]        slope,
    output logic                 inf,
    output logic                 ovf
);
    localparam int DW   = CW + 1;
    localparam int FW   = QW - 1;
    localparam int CNTW = (FW > 1) ? $clog2(FW) : 1;
    localparam logic [CNTW-1:0] LAST_STEP = CNTW'(FW - 1);

    slope_state_e state, nxt;

    logic signed [CW-1:0] lx1, ly1, lx2, ly2;
    logic [DW-1:0]        run_mag_c, rise_mag_c;
    logic                 run_neg_c, rise_neg_c;
    logic [DW-1:0]        run_mag, rise_mag;
    logic                 run_neg, rise_neg;
    logic                 pend_inf, pend_ovf;
    logic                 zero_run, big_rise;
    logic [CNTW-1:0]      cnt;
    logic [FW-1:0]        quo;
    logic [QW-1:0]        code;
    logic                 accept, div_load, div_step;

    // State register
    always_ff @(posedge clk) begin
        if (rst) state <= S_IDLE;
        else     state <= nxt;
    end

    always_comb begin
        zero_run = (run_mag == '0);
        big_rise = (rise_mag >= run_mag);
    end

    // Next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE:  if (start) nxt = S_DIFF;
            S_DIFF:  nxt = S_CLASS;
            S_CLASS: nxt = (zero_run || big_rise) ? S_PACK : S_DIV;
            S_DIV:   if (cnt == LAST_STEP) nxt = S_PACK;
            S_PACK:  nxt = S_DONE;
            S_DONE:  nxt = S_IDLE;
            default: nxt = S_IDLE;
        endcase
    end

    // Output and control decode
    always_comb begin
        busy     = 1'b1;
        done     = 1'b0;
        accept   = 1'b0;
        div_load = 1'b0;
        div_step = 1'b0;
        unique case (state)
            S_IDLE: begin
                busy   = 1'b0;
                accept = start;
            end
            S_CLASS: div_load = 1'b1;
            S_DIV:   div_step = 1'b1;
            S_DONE:  done     = 1'b1;
            default: ;
        endcase
    end

    // Operand capture
    always_ff @(posedge clk) begin
        if (rst) begin
            lx1 <= '0; ly1 <= '0; lx2 <= '0; ly2 <= '0;
        end else if (accept) begin
            lx1 <= x1; ly1 <= y1; lx2 <= x2; ly2 <= y2;
        end
    end

    slope_diff #(.CW(CW)) u_diff (
        .px1      (lx1),
        .py1      (ly1),
        .px2      (lx2),
        .py2      (ly2),
        .run_mag  (run_mag_c),
        .run_neg  (run_neg_c),
        .rise_mag (rise_mag_c),
        .rise_neg (rise_neg_c)
    );

    // Difference registers, classification flags and step counter
    always_ff @(posedge clk) begin
        if (rst) begin
            run_mag  <= '0;
            rise_mag <= '0;
            run_neg  <= 1'b0;
            rise_neg <= 1'b0;
            pend_inf <= 1'b0;
            pend_ovf <= 1'b0;
            cnt      <= '0;
        end else begin
            if (state == S_DIFF) begin
                run_mag  <= run_mag_c;
                rise_mag <= rise_mag_c;
                run_neg  <= run_neg_c;
                rise_neg <= rise_neg_c;
            end
            if (state == S_CLASS) begin
                pend_inf <= zero_run;
                pend_ovf <= !zero_run && big_rise;
                cnt      <= '0;
            end else if (div_step) begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    slope_serdiv #(.DW(DW), .FW(FW)) u_div (
        .clk  (clk),
        .rst  (rst),
        .load (div_load),
        .step (div_step),
        .num  (rise_mag),
        .den  (run_mag),
        .quo  (quo)
    );

    slope_fmt #(.QW(QW)) u_fmt (
        .quo      (quo),
        .rise_neg (rise_neg),
        .run_neg  (run_neg),
        .is_inf   (pend_inf),
        .is_ovf   (pend_ovf),
        .code     (code)
    );

    // Result registers
    always_ff @(posedge clk) begin
        if (rst) begin
            slope <= '0;
            inf   <= 1'b0;
            ovf   <= 1'b0;
        end else if (state == S_PACK) begin
            slope <= code;
            inf   <= pend_inf;
            ovf   <= pend_ovf;
        end
    end
endmodule

// File: rtl/slope_calc_chk.sv
module slope_calc_chk #(
    parameter int QW = 16
) (
    input logic          clk,
    input logic          rst,
    input logic          start,
    input logic          busy,
    input logic          done,
    input logic [QW-1:0] slope,
    input logic          inf,
    input logic          ovf
);
    localparam logic [QW-1:0] POS_FULL = {1'b0, {(QW-1){1'b1}}};
    localparam logic [QW-1:0] NEG_FULL = {1'b1, {(QW-1){1'b0}}};

    a_r5_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    a_r6_busy_ends_after_done: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> $past(done));

    a_r6_done_while_busy: assert property (@(posedge clk) disable iff (rst)
        done |-> busy);

    a_r3_flags_exclusive: assert property (@(posedge clk) disable iff (rst)
        $onehot0({inf, ovf}));

    a_r3_ovf_full_scale: assert property (@(posedge clk) disable iff (rst)
        (done && ovf) |-> (slope == POS_FULL || slope == NEG_FULL));

    a_r4_inf_full_scale: assert property (@(posedge clk) disable iff (rst)
        (done && inf) |-> (slope == POS_FULL || slope == NEG_FULL));

    a_r8_hold_idle: assert property (@(posedge clk) disable iff (rst)
        (!busy && !start) |=> ($stable(slope) && $stable(inf) && $stable(ovf)));
endmodule

bind slope_calc slope_calc_chk #(.QW(QW)) u_chk (
    .clk   (clk),
    .rst   (rst),
    .start (start),
    .busy  (busy),
    .done  (done),
    .slope (slope),
    .inf   (inf),
    .ovf   (ovf)
);

// File: tb/slope_calc_tb.sv
module slope_calc_tb;
    localparam int CW = 16;
    localparam int QW = 16;
    localparam int FW = QW - 1;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic signed [CW-1:0] x1 = '0, y1 = '0, x2 = '0, y2 = '0;
    logic busy, done, inf, ovf;
    logic [QW-1:0] slope;

    int checks = 0;
    int failures = 0;
    int cycles = 0;

    always #5 clk = ~clk;

    slope_calc #(.CW(CW), .QW(QW)) u_dut (
        .clk(clk), .rst(rst), .start(start),
        .x1(x1), .y1(y1), .x2(x2), .y2(y2),
        .busy(busy), .done(done), .slope(slope), .inf(inf), .ovf(ovf)
    );

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            failures = failures + 1;
            $display("FAIL watchdog: run hung (actual cycles=%0d expected < 150000)", cycles);
            finish_run();
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks = checks + 1;
        if (!ok) begin
            failures = failures + 1;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic void model(input longint rise, input longint run,
                                  output logic [QW-1:0] q, output bit e_inf, output bit e_ovf);
        longint ar, an, m;
        bit neg;
        e_inf = 0; e_ovf = 0;
        if (run == 0) begin
            e_inf = 1;
            q = (rise < 0) ? {1'b1, {FW{1'b0}}} : {1'b0, {FW{1'b1}}};
        end else begin
            ar  = (rise < 0) ? -rise : rise;
            an  = (run  < 0) ? -run  : run;
            neg = (rise < 0) ^ (run < 0);
            if (ar >= an) begin
                e_ovf = 1;
                q = neg ? {1'b1, {FW{1'b0}}} : {1'b0, {FW{1'b1}}};
            end else begin
                m = (ar << FW) / an;
                q = neg ? QW'(-m) : QW'(m);
            end
        end
    endfunction

    task automatic run_case(input longint ax1, input longint ay1,
                            input longint ax2, input longint ay2, input string req);
        logic [QW-1:0] eq;
        bit ei, eo;
        int lat;
        int want_lat;
        model(ay2 - ay1, ax2 - ax1, eq, ei, eo);
        @(negedge clk);
        x1 = CW'(ax1); y1 = CW'(ay1); x2 = CW'(ax2); y2 = CW'(ay2);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lat = 1;
        while (!done && lat < QW + 20) begin
            @(negedge clk);
            lat = lat + 1;
        end
        want_lat = (ei || eo) ? 4 : QW + 3;
        check(done == 1'b1, req, "done seen", done, 1);
        check(slope == eq, req, "slope code", slope, eq);
        check(inf == ei, req, "inf flag", inf, ei);
        check(ovf == eo, req, "ovf flag", ovf, eo);
        check(lat == want_lat, "R5", "done latency", lat, want_lat);
        @(negedge clk);
        check(done == 1'b0 && busy == 1'b0, "R5", "done single cycle / idle", {busy, done}, 0);
        check(slope == eq, "R8", "result held", slope, eq);
    endtask

    initial begin
        logic [QW-1:0] kq;
        bit ki, ko;
        int extra;
        void'($urandom(32'd24680));
        repeat (3) @(negedge clk);
        // R7: reset state
        check(busy == 0 && done == 0, "R7", "busy/done after reset", {busy, done}, 0);
        check(slope == 0 && inf == 0 && ovf == 0, "R7", "outputs after reset", slope, 0);
        rst = 1'b0;

        // R1, R2: in-range values, both signs
        run_case(0, 0, 4, 1, "R1");
        run_case(0, 0, 4, -1, "R2");
        run_case(10, 3, 3, 5, "R1");
        run_case(-7, -7, 0, -7, "R1");
        run_case(0, 0, 1000, 14, "R2");
        run_case(-32768, -32768, 32767, 32766, "R1");
        run_case(3, 0, 0, 2, "R1");
        // R3: overflow both signs and equality boundary
        run_case(0, 0, 5, 5, "R3");
        run_case(0, 0, 5, -5, "R3");
        run_case(5, 0, 0, 9, "R3");
        run_case(5, 0, 0, -9, "R3");
        // R4: zero run
        run_case(9, 1, 9, 6, "R4");
        run_case(9, 6, 9, 1, "R4");
        run_case(9, 2, 9, 2, "R4");

        // R6: start while busy is ignored
        model(1, 3, kq, ki, ko);
        @(negedge clk);
        x1 = 0; y1 = 0; x2 = 3; y2 = 1; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(busy == 1'b1, "R6", "busy after start", busy, 1);
        repeat (5) @(negedge clk);
        x1 = 0; y1 = 0; x2 = 0; y2 = 7; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (!done) @(negedge clk);
        check(slope == kq, "R6", "slope unaffected by busy start", slope, kq);
        check(inf == 1'b0, "R6", "no inf from ignored start", inf, 0);
        extra = 0;
        @(negedge clk);
        repeat (QW + 6) begin
            if (done || busy) extra = extra + 1;
            @(negedge clk);
        end
        check(extra == 0, "R6", "no second operation", extra, 0);

        // Random coordinates, mostly small rises
        for (int i = 0; i < 300; i++) begin
            longint ax1, ay1, ax2, ay2;
            ax1 = longint'($signed(16'($urandom)));
            ax2 = longint'($signed(16'($urandom)));
            ay1 = longint'($signed(16'($urandom % 2000))) - 1000;
            if (i % 4 == 0) ay2 = longint'($signed(16'($urandom)));
            else            ay2 = ay1 + longint'($urandom % 600) - 300;
            if (i % 25 == 0) ax2 = ax1;
            run_case(ax1, ay1, ax2, ay2, "R1");
        end

        // R7: reset mid-operation
        @(negedge clk);
        x1 = 0; y1 = 0; x2 = 8; y2 = 1; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (4) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check(busy == 0 && done == 0, "R7", "reset aborts operation", {busy, done}, 0);
        check(slope == 0 && inf == 0 && ovf == 0, "R7", "reset clears result", slope, 0);

        finish_run();
    end
endmodule